// File: doc/BRIEF.md
# Staged Block-Wise Copy Engine

This engine carries out the middle and final stages of a memory copy that has already been set up by an earlier preparation step. It loads three working registers (a byte count, a source pointer and a destination pointer), a scheme select, a direction flag and a stage select on a start pulse. It then moves bytes over a single-byte memory port, one block at a time, forward or backward through memory.

Two encodings of the working registers are supported. In scheme A, the count is signed and the pointers are biased bases, so each block's address is base plus count. In scheme B, the count is a plain remaining length and the pointers walk themselves. After each complete block the three registers are committed. When an access faults, the engine stops at once and leaves the registers describing only the blocks that finished, so the copy can resume from that point.

Top module: `stage_copy_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `fault` and `mem_req` are all 0.
- R2: The copy runs forward when bit RW-1 of the count is set, or when scheme B is selected (`scheme_b`=1) and `neg_flag`=0. In every other case it runs backward. In scheme A, `neg_flag` has no effect. The remaining length is the two's-complement magnitude of the count in scheme A and the count itself in scheme B.
- R3: With `epilogue`=0, only full blocks of BLK bytes are copied. The engine stops with no fault once fewer than BLK bytes remain, leaving that remainder in the count. A run that starts with fewer than BLK bytes makes no memory access.
- R4: With `epilogue`=1, the engine copies everything that remains, ending with a final block shorter than BLK if needed. On completion without a fault, `cnt_out` is 0.
- R5: In scheme A forward, each block is read at src+count and written at dst+count. After the block succeeds, the count rises by the block length, and the pointers do not change.
- R6: In scheme A backward, the count is first lowered by the block length, and the block is then copied at src+count and dst+count. A block that fails leaves the count as it was before that block.
- R7: In scheme B forward, a block is copied starting at the current pointers. After success, both pointers rise by the block length and the count falls by the same amount.
- R8: In scheme B backward, a block is copied starting at pointer minus the block length. After success, both pointers fall by the block length and the count falls by the same amount.
- R9: Each byte is read in one cycle and written in the next. Inside a block, bytes go in ascending address order when forward and in descending order when backward. This makes overlapping copies give the same result as copying from an untouched original.
- R10: A faulting access ends the run in that same cycle, with no further memory access. `done` and `fault` are raised, and the registers keep the values from the last completed block.
- R11: `busy` is 1 from the cycle after `start` until the run ends. `done` is a single-cycle pulse. `fault` holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Loads the inputs and begins a run when idle |
| scheme_b | input | 1 | 0: signed count with biased bases, 1: self-advancing pointers |
| neg_flag | input | 1 | Direction flag from the preparation step (scheme B only) |
| epilogue | input | 1 | 0: full blocks only, 1: finish the copy |
| cnt_in | input | RW | Initial count register |
| src_in | input | RW | Initial source register |
| dst_in | input | RW | Initial destination register |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fault | output | 1 | Last run ended on a faulting access |
| cnt_out | output | RW | Current count register |
| src_out | output | RW | Current source register |
| dst_out | output | RW | Current destination register |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | RW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the request cycle |
| mem_fault | input | 1 | Access in this cycle failed |

## Verification
The bench builds the engine with RW=16 and BLK=4. With a block this small, a handful of bytes is enough to exercise several full blocks, a leftover shorter than a block, and a main-stage run that has nothing to do. The 256-byte model decodes only the low address byte, so the base-plus-negative-count wrap in scheme A is exercised with short counts. Faults can be placed on one chosen read or write, so rollback is tested on the first block, on a later block, and on the write half of a byte.

// File: rtl/stage_copy_pkg.sv
package stage_copy_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PLAN = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } st_e;
endpackage

// File: rtl/stage_copy_plan.sv
// Works out, from the committed registers, the length and base addresses
// of the next block and the register values to commit if it succeeds.
module stage_copy_plan #(
    parameter int RW  = 16,
    parameter int BLK = 8,
    parameter int LW  = $clog2(BLK + 1)
) (
    input  logic [RW-1:0] cnt,
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] dst,
    input  logic          scheme_b,
    input  logic          neg_flag,
    input  logic          epilogue,
    output logic          fwd,
    output logic [RW-1:0] rem,
    output logic [LW-1:0] len,
    output logic [RW-1:0] base_s,
    output logic [RW-1:0] base_d,
    output logic [RW-1:0] nxt_cnt,
    output logic [RW-1:0] nxt_src,
    output logic [RW-1:0] nxt_dst
);
    localparam logic [RW-1:0] BLK_W = RW'(BLK);

    logic          neg;
    logic [RW-1:0] lenw;
    logic [RW-1:0] tcnt;

    always_comb begin
        neg  = cnt[RW-1];
        fwd  = neg | (scheme_b & ~neg_flag);
        rem  = (!scheme_b && neg) ? (~cnt + 1'b1) : cnt;
        if (rem >= BLK_W)  len = LW'(BLK);
        else if (epilogue) len = rem[LW-1:0];
        else               len = '0;
        lenw = {{(RW-LW){1'b0}}, len};
        tcnt = cnt - lenw;

        base_s  = src;
        base_d  = dst;
        nxt_cnt = cnt;
        nxt_src = src;
        nxt_dst = dst;
        if (!scheme_b) begin
            if (fwd) begin
                base_s  = src + cnt;
                base_d  = dst + cnt;
                nxt_cnt = cnt + lenw;
            end else begin
                base_s  = src + tcnt;
                base_d  = dst + tcnt;
                nxt_cnt = tcnt;
            end
        end else begin
            nxt_cnt = tcnt;
            if (fwd) begin
                nxt_src = src + lenw;
                nxt_dst = dst + lenw;
            end else begin
                base_s  = src - lenw;
                base_d  = dst - lenw;
                nxt_src = src - lenw;
                nxt_dst = dst - lenw;
            end
        end
    end
endmodule

// File: rtl/stage_copy_addr.sv
// Byte address inside the current block: ascending forward, descending backward.
module stage_copy_addr #(
    parameter int RW = 16,
    parameter int LW = 4
) (
    input  logic [RW-1:0] base_s,
    input  logic [RW-1:0] base_d,
    input  logic [LW-1:0] idx,
    input  logic [LW-1:0] len,
    input  logic          fwd,
    input  logic          sel_dst,
    output logic [RW-1:0] addr
);
    logic [LW-1:0] off;

    always_comb begin
        off  = fwd ? idx : (len - idx - LW'(1));
        addr = (sel_dst ? base_d : base_s) + {{(RW-LW){1'b0}}, off};
    end
endmodule

// File: rtl/stage_copy_engine.sv
module stage_copy_engine
    import stage_copy_pkg::*;
#(
    parameter int RW  = 16,
    parameter int BLK = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          scheme_b,
    input  logic          neg_flag,
    input  logic          epilogue,
    input  logic [RW-1:0] cnt_in,
    input  logic [RW-1:0] src_in,
    input  logic [RW-1:0] dst_in,
    output logic          busy,
    output logic          done,
    output logic          fault,
    output logic [RW-1:0] cnt_out,
    output logic [RW-1:0] src_out,
    output logic [RW-1:0] dst_out,
    output logic          mem_req,
    output logic          mem_we,
    output logic [RW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_fault
);
    localparam int LW = $clog2(BLK + 1);

    typedef struct packed {
        st_e           st;
        logic [RW-1:0] cnt;
        logic [RW-1:0] src;
        logic [RW-1:0] dst;
        logic          sch_b;
        logic          nflag;
        logic          epi;
        logic [LW-1:0] idx;
        logic [7:0]    byte_v;
        logic          done;
        logic          fault;
    } regs_t;

    regs_t r_q, r_d;

    logic          fwd;
    logic [RW-1:0] rem;
    logic [LW-1:0] len;
    logic [RW-1:0] base_s, base_d, nxt_cnt, nxt_src, nxt_dst;

    stage_copy_plan #(.RW(RW), .BLK(BLK), .LW(LW)) u_plan (
        .cnt(r_q.cnt), .src(r_q.src), .dst(r_q.dst),
        .scheme_b(r_q.sch_b), .neg_flag(r_q.nflag), .epilogue(r_q.epi),
        .fwd(fwd), .rem(rem), .len(len),
        .base_s(base_s), .base_d(base_d),
        .nxt_cnt(nxt_cnt), .nxt_src(nxt_src), .nxt_dst(nxt_dst)
    );

    stage_copy_addr #(.RW(RW), .LW(LW)) u_addr (
        .base_s(base_s), .base_d(base_d), .idx(r_q.idx), .len(len),
        .fwd(fwd), .sel_dst(r_q.st == ST_WR), .addr(mem_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: if (start) begin
                r_d.cnt   = cnt_in;
                r_d.src   = src_in;
                r_d.dst   = dst_in;
                r_d.sch_b = scheme_b;
                r_d.nflag = neg_flag;
                r_d.epi   = epilogue;
                r_d.fault = 1'b0;
                r_d.st    = ST_PLAN;
            end
            ST_PLAN: begin
                r_d.idx = '0;
                if (len == '0) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.st = ST_RD;
                end
            end
            ST_RD: begin
                r_d.byte_v = mem_rdata;
                if (mem_fault) begin
                    r_d.done  = 1'b1;
                    r_d.fault = 1'b1;
                    r_d.st    = ST_IDLE;
                end else begin
                    r_d.st = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_fault) begin
                    r_d.done  = 1'b1;
                    r_d.fault = 1'b1;
                    r_d.st    = ST_IDLE;
                end else if (r_q.idx == len - LW'(1)) begin
                    r_d.cnt = nxt_cnt;
                    r_d.src = nxt_src;
                    r_d.dst = nxt_dst;
                    r_d.st  = ST_PLAN;
                end else begin
                    r_d.idx = r_q.idx + LW'(1);
                    r_d.st  = ST_RD;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign fault     = r_q.fault;
    assign cnt_out   = r_q.cnt;
    assign src_out   = r_q.src;
    assign dst_out   = r_q.dst;
    assign mem_req   = (r_q.st == ST_RD) || (r_q.st == ST_WR);
    assign mem_we    = (r_q.st == ST_WR);
    assign mem_wdata = r_q.byte_v;

    p_req_when_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_write_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we));
    p_stop_on_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_fault) |=> (!mem_req && done && fault));
    p_regs_hold_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> ($stable(cnt_out) && $stable(src_out) && $stable(dst_out)));
    p_epi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && r_q.epi) |-> (cnt_out == '0));
    p_main_leftover_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && !r_q.epi) |-> (rem < RW'(BLK)));
endmodule

// File: tb/sim_stage_copy_engine.sv
module sim_stage_copy_engine;
    localparam int RW  = 16;
    localparam int BLK = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, scheme_b = 1'b0, neg_flag = 1'b0, epilogue = 1'b0;
    logic [RW-1:0] cnt_in = '0, src_in = '0, dst_in = '0;
    logic          busy, done, fault, mem_req, mem_we, mem_fault;
    logic [RW-1:0] cnt_out, src_out, dst_out, mem_addr;
    logic [7:0]    mem_wdata, mem_rdata;

    logic [7:0] mem [0:255];
    logic       init_go = 1'b0;
    logic       flt_en = 1'b0, flt_wr = 1'b0;
    logic [7:0] flt_addr = '0;

    int checks = 0, errors = 0, cyc = 0, nreq;
    logic [RW-1:0] rc, rs, rd;
    logic          rf;

    always #10 clk = ~clk;

    stage_copy_engine #(.RW(RW), .BLK(BLK)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .scheme_b(scheme_b),
        .neg_flag(neg_flag), .epilogue(epilogue), .cnt_in(cnt_in),
        .src_in(src_in), .dst_in(dst_in), .busy(busy), .done(done),
        .fault(fault), .cnt_out(cnt_out), .src_out(src_out), .dst_out(dst_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_fault(mem_fault)
    );

    function automatic logic [7:0] orig(input logic [7:0] a);
        return 8'(a * 7 + 3);
    endfunction

    always_comb begin
        mem_rdata = mem[mem_addr[7:0]];
        mem_fault = flt_en && mem_req && (mem_addr[7:0] == flt_addr) && (mem_we == flt_wr);
    end

    always @(posedge clk) begin
        if (init_go) begin
            for (int i = 0; i < 256; i++) mem[i] <= orig(8'(i));
        end else if (mem_req && mem_we && !mem_fault) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL R11 watchdog expired actual=%0d expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic init_mem();
        @(negedge clk); init_go = 1'b1;
        @(negedge clk); init_go = 1'b0;
    endtask

    task automatic run(input logic sb, input logic nf, input logic ep,
                       input logic [RW-1:0] c, input logic [RW-1:0] s, input logic [RW-1:0] d);
        int n;
        @(negedge clk);
        scheme_b = sb; neg_flag = nf; epilogue = ep;
        cnt_in = c; src_in = s; dst_in = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11 busy after start", 64'(busy), 64'd1);
        nreq = 0; n = 0;
        while (!done && n < 4000) begin
            if (mem_req) nreq++;
            @(negedge clk);
            n++;
        end
        chk(n < 4000, "R11 run finished", 64'(n), 64'd4000);
        rc = cnt_out; rs = src_out; rd = dst_out; rf = fault;
        @(negedge clk);
        chk(!done && !busy, "R11 done pulse then idle", 64'({done, busy}), 64'd0);
    endtask

    task automatic chk_copy(input logic [7:0] s, input logic [7:0] d, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            logic [7:0] da;
            da = d + 8'(k);
            chk(mem[da] == orig(s + 8'(k)), tag, 64'(mem[da]), 64'(orig(s + 8'(k))));
        end
    endtask

    task automatic chk_same(input logic [7:0] a, input string tag);
        chk(mem[a] == orig(a), tag, 64'(mem[a]), 64'(orig(a)));
    endtask

    task automatic t_reset();
        chk({busy, done, fault, mem_req} == 4'b0, "R1 reset idle", 64'({busy, done, fault, mem_req}), 64'd0);
    endtask

    task automatic t_a_fwd();
        init_mem();
        run(1'b0, 1'b0, 1'b0, 16'hFFF6, 16'h001A, 16'h004A);
        chk(rc == 16'hFFFE, "R3 R5 main count", 64'(rc), 64'hFFFE);
        chk(rs == 16'h001A && rd == 16'h004A, "R5 pointers fixed", 64'({rs, rd}), 64'h001A004A);
        chk(!rf && nreq == 16, "R3 two blocks no fault", 64'(nreq), 64'd16);
        chk_copy(8'h10, 8'h40, 8, "R5 fwd data");
        chk_same(8'h48, "R3 remainder untouched");
        run(1'b0, 1'b0, 1'b1, rc, rs, rd);
        chk(rc == 16'h0 && !rf, "R4 epilogue count zero", 64'(rc), 64'd0);
        chk(nreq == 4, "R4 short block accesses", 64'(nreq), 64'd4);
        chk_copy(8'h18, 8'h48, 2, "R4 tail data");
        chk_same(8'h4A, "R4 past end untouched");
    endtask

    task automatic t_a_bwd();
        init_mem();
        run(1'b0, 1'b0, 1'b0, 16'd6, 16'h0080, 16'h0090);
        chk(rc == 16'd2 && rs == 16'h0080 && rd == 16'h0090, "R6 main regs", 64'(rc), 64'd2);
        chk_copy(8'h82, 8'h92, 4, "R6 bwd block data");
        chk_same(8'h91, "R6 below block untouched");
        chk_same(8'h96, "R6 above block untouched");
        run(1'b0, 1'b0, 1'b1, rc, rs, rd);
        chk(rc == 16'd0 && !rf, "R4 R6 epilogue zero", 64'(rc), 64'd0);
        chk_copy(8'h80, 8'h90, 2, "R4 R6 tail data");
    endtask

    task automatic t_b_fwd();
        init_mem();
        run(1'b1, 1'b0, 1'b0, 16'd7, 16'h0020, 16'h0060);
        chk(rc == 16'd3 && rs == 16'h0024 && rd == 16'h0064, "R7 main regs", 64'({rc, rs, rd}), 64'h000300240064);
        chk_same(8'h64, "R7 remainder untouched");
        run(1'b1, 1'b0, 1'b1, rc, rs, rd);
        chk(rc == 16'd0 && rs == 16'h0027 && rd == 16'h0067, "R4 R7 epilogue regs", 64'({rc, rs, rd}), 64'h000000270067);
        chk_copy(8'h20, 8'h60, 7, "R7 data");
    endtask

    task automatic t_b_bwd();
        init_mem();
        run(1'b1, 1'b1, 1'b0, 16'd5, 16'h00A5, 16'h00C5);
        chk(rc == 16'd1 && rs == 16'h00A1 && rd == 16'h00C1, "R2 R8 main regs", 64'({rc, rs, rd}), 64'h000100A100C1);
        chk_same(8'hC0, "R8 remainder untouched");
        run(1'b1, 1'b1, 1'b1, rc, rs, rd);
        chk(rc == 16'd0 && rs == 16'h00A0 && rd == 16'h00C0, "R4 R8 epilogue regs", 64'({rc, rs, rd}), 64'h000000A000C0);
        chk_copy(8'hA0, 8'hC0, 5, "R8 data");
    endtask

    task automatic t_dir_flag_ignored();
        init_mem();
        run(1'b0, 1'b1, 1'b1, 16'd4, 16'h0050, 16'h00E0);
        chk(rc == 16'd0, "R2 scheme A positive count is backward", 64'(rc), 64'd0);
        chk_copy(8'h50, 8'hE0, 4, "R2 backward data");
    endtask

    task automatic t_overlap();
        init_mem();
        run(1'b1, 1'b1, 1'b1, 16'd4, 16'h0034, 16'h0035);
        chk_copy(8'h30, 8'h31, 4, "R9 backward overlap order");
        init_mem();
        run(1'b0, 1'b0, 1'b1, 16'hFFFC, 16'h0035, 16'h0034);
        chk_copy(8'h31, 8'h30, 4, "R9 forward overlap order");
    endtask

    task automatic t_short_main();
        init_mem();
        run(1'b0, 1'b0, 1'b0, 16'd3, 16'h0050, 16'h0070);
        chk(rc == 16'd3 && !rf, "R3 short main leaves count", 64'(rc), 64'd3);
        chk(nreq == 0, "R3 short main no access", 64'(nreq), 64'd0);
    endtask

    task automatic t_faults();
        init_mem();
        flt_en = 1'b1; flt_wr = 1'b0; flt_addr = 8'h15;
        run(1'b0, 1'b0, 1'b0, 16'hFFF4, 16'h001C, 16'h004C);
        chk(rf == 1'b1, "R10 fault raised", 64'(rf), 64'd1);
        chk(rc == 16'hFFF8, "R10 R5 count after one block", 64'(rc), 64'hFFF8);
        chk(nreq == 11, "R10 stop at faulting read", 64'(nreq), 64'd11);
        chk_same(8'h45, "R10 no write after fault");
        init_mem();
        flt_wr = 1'b1; flt_addr = 8'h93;
        run(1'b0, 1'b0, 1'b0, 16'd8, 16'h0080, 16'h0090);
        chk(rf && rc == 16'd4, "R6 R10 backward rollback", 64'(rc), 64'd4);
        chk(nreq == 10, "R10 stop at faulting write", 64'(nreq), 64'd10);
        chk_same(8'h93, "R10 faulted write dropped");
        init_mem();
        flt_wr = 1'b0; flt_addr = 8'hA7;
        run(1'b1, 1'b1, 1'b0, 16'd8, 16'h00A8, 16'h00C8);
        chk(rf && rc == 16'd8 && rs == 16'h00A8 && rd == 16'h00C8, "R8 R10 first block fault keeps regs",
            64'({rc, rs, rd}), 64'h000800A800C8);
        chk(nreq == 1, "R10 single access", 64'(nreq), 64'd1);
        flt_en = 1'b0;
        run(1'b1, 1'b0, 1'b1, 16'd1, 16'h0010, 16'h0011);
        chk(rf == 1'b0, "R11 fault cleared by new run", 64'(rf), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_a_fwd();
        t_a_bwd();
        t_b_fwd();
        t_b_bwd();
        t_dir_flag_ignored();
        t_overlap();
        t_short_main();
        t_faults();
        summary();
        $finish;
    end
endmodule